// File: doc/BRIEF.md
# Execution pipe steering unit

This block sits between dispatch and the execution resources of a core. Each cycle it may take in one typed micro-op over a ready/valid handshake and decide where it goes. Integer micro-ops go straight to one of three ALU ports. Multiplies always use ALU 0 and bit-count operations (leading-zero count, population count) always use ALU 2. All other integer work rotates among the three ALUs.

Floating-point and vector micro-ops are placed into one of three typed pipe queues: an add pipe, a multiply pipe and a store/convert pipe. Each queue holds a parameterised number of entries (12 by default), and each queue drains through its own ready/valid output. The three queues can issue in the same cycle. Some operations are legal on more than one pipe, such as logical operations and moves. These go to the legal pipe whose queue has the most room.

The input stalls when the destination it needs cannot take the micro-op. For integer work that destination is the chosen ALU port. For floating-point work it is the queue or queues the operation is allowed to use.

Top module: `pipe_steer`

## Requirements
- R1: A micro-op with class code 1 (integer multiply) raises only `alu_valid[0]`, and it is accepted only when `alu_ready[0]` is high.
- R2: A micro-op with class code 2 (integer bit count) raises only `alu_valid[2]`, and it is accepted only when `alu_ready[2]` is high.
- R3: A micro-op with class code 0 (general integer) goes to the ALU named by a rotating pointer. The pointer starts at 0 after reset. It steps 0→1→2→0 on each accepted code-0 micro-op, and codes 1 and 2 leave it unchanged.
- R4: For integer classes, `in_ready` equals the ready bit of the selected ALU and `alu_data` equals `in_data`. At most one `alu_valid` bit is ever high, and none is high when `in_valid` is low or the class is floating-point (codes 3 to 7).
- R5: Class code 3 (fp add/subtract/compare) goes only to queue 0, code 4 (fp multiply/divide) only to queue 1, and code 7 (store/convert/load) only to queue 2.
- R6: Class code 5 (fp logical) may use queues 0 or 1, and code 6 (move) may use any queue. Among the legal queues that are not full, the one with the most free entries is chosen, and a tie goes to the lower index.
- R7: Each queue holds at most DEPTH entries. A floating-point micro-op whose legal queues are all full sees `in_ready` low and is not stored.
- R8: Each queue presents its entries in arrival order. `fp_valid[i]` is high exactly when queue i is non-empty. A held entry keeps its data stable while `fp_ready[i]` is low. The three queues pop independently in the same cycle.
- R9: After reset all queues are empty, no output valid is high, and the rotating pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op taken this cycle |
| in_cls | input | 3 | Operation class code (0..7) |
| in_data | input | W | Micro-op payload |
| alu_valid | output | 3 | One-hot ALU request |
| alu_ready | input | 3 | ALU can accept |
| alu_data | output | W | Payload to the ALUs |
| fp_valid | output | 3 | Queue i has an entry |
| fp_ready | input | 3 | Pipe i takes its head entry |
| fp_data | output | 3*W | Head entry of queue i at bits [i*W +: W] |

## Verification
A wrong rotating pointer shows up at once as the wrong `alu_valid` bit on the next general integer op. A corrupt queue count shows up in two ways. A flexible op may be placed in a different queue, which appears as an unexpected `fp_valid` rise one cycle later. Or `in_ready` is wrong when a queue is near full. A bad head or tail pointer shows up as wrong or out-of-order `fp_data` when that entry reaches the head, which can be up to DEPTH pops later. The bench therefore compares every output against a queue model on every cycle.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int NUM_ALU = 3;
    localparam int NUM_FPP = 3;

    typedef enum logic [2:0] {
        OP_INT_GEN    = 3'd0,
        OP_INT_MUL    = 3'd1,
        OP_INT_BITCNT = 3'd2,
        OP_FP_ADD     = 3'd3,
        OP_FP_MUL     = 3'd4,
        OP_FP_LOGIC   = 3'd5,
        OP_FP_MOVE    = 3'd6,
        OP_FP_STORE   = 3'd7
    } op_cls_e;

    // legal floating-point queues per class (bit i = queue i)
    function automatic logic [NUM_FPP-1:0] fp_legal(op_cls_e c);
        case (c)
            OP_FP_ADD:   return 3'b001;
            OP_FP_MUL:   return 3'b010;
            OP_FP_LOGIC: return 3'b011;
            OP_FP_MOVE:  return 3'b111;
            OP_FP_STORE: return 3'b100;
            default:     return 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/steer_fifo.sv
module steer_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 12,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop_ready,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop;

    function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop     = (st_q.cnt != '0) && pop_ready;
        if (push_ok) st_d.tail = wrap_inc(st_q.tail);
        if (pop)     st_d.head = wrap_inc(st_q.head);
        if (push_ok && !pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.tail] <= push_data;
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = mem_q[st_q.head];
    assign count     = st_q.cnt;
endmodule

// File: rtl/steer_int_pick.sv
module steer_int_pick
    import steer_pkg::*;
#(
    localparam int RRW = $clog2(NUM_ALU)
) (
    input  op_cls_e              cls,
    input  logic [RRW-1:0]       rr,
    output logic [NUM_ALU-1:0]   sel
);
    always_comb begin
        case (cls)
            OP_INT_MUL:    sel = NUM_ALU'(1);
            OP_INT_BITCNT: sel = NUM_ALU'(1) << (NUM_ALU - 1);
            OP_INT_GEN:    sel = NUM_ALU'(1) << rr;
            default:       sel = '0;
        endcase
    end
endmodule

// File: rtl/steer_fp_pick.sv
module steer_fp_pick
    import steer_pkg::*;
#(
    parameter int DEPTH = 12,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  op_cls_e                      cls,
    input  logic [NUM_FPP-1:0][CW-1:0]   cnt,
    output logic [NUM_FPP-1:0]           sel
);
    logic [NUM_FPP-1:0] legal;
    logic [CW-1:0]      best;
    logic [CW-1:0]      free;

    always_comb begin
        legal = fp_legal(cls);
        sel   = '0;
        best  = '0;
        for (int i = 0; i < NUM_FPP; i++) begin
            free = CW'(DEPTH) - cnt[i];
            // strict compare keeps the lower index on a tie
            if (legal[i] && (free > best)) begin
                sel    = '0;
                sel[i] = 1'b1;
                best   = free;
            end
        end
    end
endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
    import steer_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 12,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int RRW  = $clog2(NUM_ALU)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_cls,
    input  logic [W-1:0]         in_data,
    output logic [NUM_ALU-1:0]   alu_valid,
    input  logic [NUM_ALU-1:0]   alu_ready,
    output logic [W-1:0]         alu_data,
    output logic [NUM_FPP-1:0]   fp_valid,
    input  logic [NUM_FPP-1:0]   fp_ready,
    output logic [NUM_FPP*W-1:0] fp_data
);
    typedef struct packed {
        logic [RRW-1:0] rr;
    } top_st_t;

    top_st_t st_d, st_q;
    op_cls_e cls;
    logic    is_fp;
    logic [NUM_ALU-1:0]         int_sel;
    logic [NUM_FPP-1:0]         fp_sel;
    logic [NUM_FPP-1:0][CW-1:0] q_cnt;

    assign cls   = op_cls_e'(in_cls);
    assign is_fp = (in_cls >= 3'd3);

    steer_int_pick u_int_pick (
        .cls (cls),
        .rr  (st_q.rr),
        .sel (int_sel)
    );

    steer_fp_pick #(.DEPTH(DEPTH)) u_fp_pick (
        .cls (cls),
        .cnt (q_cnt),
        .sel (fp_sel)
    );

    for (genvar g = 0; g < NUM_FPP; g++) begin : g_q
        steer_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (in_valid && is_fp && fp_sel[g]),
            .push_data (in_data),
            .pop_ready (fp_ready[g]),
            .out_valid (fp_valid[g]),
            .out_data  (fp_data[g*W +: W]),
            .count     (q_cnt[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        in_ready  = is_fp ? (fp_sel != '0) : ((int_sel & alu_ready) != '0);
        alu_valid = (in_valid && !is_fp) ? int_sel : '0;
        alu_data  = in_data;
        if (in_valid && in_ready && cls == OP_INT_GEN)
            st_d.rr = (st_q.rr == RRW'(NUM_ALU - 1)) ? '0 : st_q.rr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
    parameter int W     = 16,
    parameter int DEPTH = 12,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_cls,
    input logic [2:0]       alu_valid,
    input logic [2:0]       alu_ready,
    input logic [2:0]       fp_valid,
    input logic [2:0]       fp_ready,
    input logic [3*W-1:0]   fp_data,
    input logic [2:0][CW-1:0] q_cnt
);
    assert_mul_alu0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd1) |-> (alu_valid == 3'b001 && in_ready == alu_ready[0]));

    assert_bitcnt_alu2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd2) |-> (alu_valid == 3'b100 && in_ready == alu_ready[2]));

    assert_alu_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alu_valid) && ((!in_valid || in_cls >= 3'd3) -> alu_valid == 3'b000));

    assert_int_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_cls < 3'd3) |-> ((alu_valid & alu_ready) != 3'b000));

    assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls == 3'd3 && q_cnt[0] == CW'(DEPTH)) |-> !in_ready);

    for (genvar i = 0; i < 3; i++) begin : g_p
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            q_cnt[i] <= CW'(DEPTH));

        assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fp_valid[i] && !fp_ready[i]) |=> (fp_valid[i] && $stable(fp_data[i*W +: W])));

        assert_valid_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fp_valid[i] == (q_cnt[i] != '0));
    end
endmodule

bind pipe_steer steer_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_cls    (in_cls),
    .alu_valid (alu_valid),
    .alu_ready (alu_ready),
    .fp_valid  (fp_valid),
    .fp_ready  (fp_ready),
    .fp_data   (fp_data),
    .q_cnt     (q_cnt)
);

// File: tb/tb_pipe_steer.sv
module tb_pipe_steer;
    localparam int W     = 16;
    localparam int DEPTH = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready;
    logic [2:0] in_cls;
    logic [W-1:0] in_data;
    logic [2:0] alu_valid, alu_ready;
    logic [W-1:0] alu_data;
    logic [2:0] fp_valid, fp_ready;
    logic [3*W-1:0] fp_data;

    int checks = 0;
    int errors = 0;
    int rr_m   = 0;
    logic [W-1:0] fq [3][$];

    always #2.5 clk = ~clk;

    pipe_steer #(.W(W), .DEPTH(DEPTH)) dut (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] legal_of(input logic [2:0] c);
        case (c)
            3'd3: return 3'b001;
            3'd4: return 3'b010;
            3'd5: return 3'b011;
            3'd6: return 3'b111;
            3'd7: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] exp_alu(input logic [2:0] c);
        case (c)
            3'd0: return 3'b001 << rr_m;
            3'd1: return 3'b001;
            3'd2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] exp_fp(input logic [2:0] c);
        logic [2:0] s = 3'b000;
        int best = 0;
        for (int i = 0; i < 3; i++) begin
            int fr = DEPTH - fq[i].size();
            if (legal_of(c)[i] && fr > best) begin
                s = 3'b001 << i;
                best = fr;
            end
        end
        return s;
    endfunction

    task automatic step(input logic v, input logic [2:0] c, input logic [W-1:0] d,
                        input logic [2:0] ar, input logic [2:0] fr);
        logic [2:0] ea, ef;
        logic er;
        string tg;
        @(negedge clk);
        in_valid = v; in_cls = c; in_data = d; alu_ready = ar; fp_ready = fr;
        #1;
        ea = v ? exp_alu(c) : 3'b000;
        ef = exp_fp(c);
        er = (c >= 3'd3) ? (ef != 3'b000) : ((exp_alu(c) & ar) != 3'b000);
        tg = (c == 3'd1) ? "R1" : (c == 3'd2) ? "R2" : (c == 3'd0) ? "R3" : "R4";
        chk(alu_valid == ea, tg, alu_valid, ea);
        if (v && c < 3'd3) chk(alu_data == d, "R4", alu_data, d);
        if (v) chk(in_ready == er, (c >= 3'd3) ? "R7" : "R4", in_ready, er);
        for (int i = 0; i < 3; i++) begin
            chk(fp_valid[i] == (fq[i].size() != 0), "R8", fp_valid[i], fq[i].size() != 0);
            if (fq[i].size() != 0)
                chk(fp_data[i*W +: W] == fq[i][0], "R8", fp_data[i*W +: W], fq[i][0]);
        end
        for (int i = 0; i < 3; i++)
            if (fq[i].size() != 0 && fr[i]) void'(fq[i].pop_front());
        if (v && er) begin
            if (c >= 3'd3) begin
                for (int i = 0; i < 3; i++) if (ef[i]) fq[i].push_back(d);
            end else if (c == 3'd0) begin
                rr_m = (rr_m + 1) % 3;
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; in_valid = 1'b0; in_cls = '0; in_data = '0;
        alu_ready = '0; fp_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R9: reset state
        chk(fp_valid == 3'b000 && alu_valid == 3'b000, "R9", {fp_valid, alu_valid}, 0);
        step(1'b1, 3'd0, 16'h0a01, 3'b111, 3'b000);   // R9 pointer at ALU 0
        // R3 rotation with pinned ops between
        step(1'b1, 3'd1, 16'h0a02, 3'b111, 3'b000);   // R1
        step(1'b1, 3'd0, 16'h0a03, 3'b111, 3'b000);   // ALU1
        step(1'b1, 3'd2, 16'h0a04, 3'b111, 3'b000);   // R2
        step(1'b1, 3'd0, 16'h0a05, 3'b111, 3'b000);   // ALU2
        step(1'b1, 3'd0, 16'h0a06, 3'b111, 3'b000);   // back to ALU0
        // R1: multiply stalls when ALU0 busy even though others ready
        step(1'b1, 3'd1, 16'h0a07, 3'b110, 3'b000);
        chk(in_ready == 1'b0, "R1", in_ready, 0);
        // R3: stalled general op keeps the pointer
        step(1'b1, 3'd0, 16'h0a08, 3'b101, 3'b000);
        step(1'b1, 3'd0, 16'h0a09, 3'b111, 3'b000);
        // R5: add into empty queues lands in queue 0
        step(1'b1, 3'd3, 16'h1000, 3'b000, 3'b000);
        step(1'b0, 3'd0, 16'h0000, 3'b000, 3'b000);
        chk(fp_valid == 3'b001, "R5", fp_valid, 3'b001);
        // R7: fill queue 0 then stall
        for (int k = 1; k < DEPTH + 2; k++) step(1'b1, 3'd3, 16'h1000 + k, 3'b000, 3'b000);
        // R6: logic op goes to queue 1 (queue 0 full)
        step(1'b1, 3'd5, 16'h2001, 3'b000, 3'b000);
        step(1'b0, 3'd0, 16'h0000, 3'b000, 3'b000);
        chk(fp_valid == 3'b011, "R6", fp_valid, 3'b011);
        // R6: move goes to queue 2 (most free)
        step(1'b1, 3'd6, 16'h3001, 3'b000, 3'b000);
        step(1'b0, 3'd0, 16'h0000, 3'b000, 3'b000);
        chk(fp_valid == 3'b111, "R6", fp_valid, 3'b111);
        // R8: drain all three in parallel
        for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 3'd0, 16'h0, 3'b000, 3'b111);
        chk(fp_valid == 3'b000, "R8", fp_valid, 0);
        // R6: tie among empty queues picks the lowest legal index
        step(1'b1, 3'd6, 16'h3002, 3'b000, 3'b000);
        step(1'b0, 3'd0, 16'h0000, 3'b000, 3'b000);
        chk(fp_valid == 3'b001, "R6", fp_valid, 3'b001);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [2:0] fr = (k % 800 < 300) ? ($urandom() % 8 == 0 ? 3'b111 : 3'b000) : 3'($urandom());
            step(1'($urandom()), 3'($urandom()), W'($urandom()), 3'($urandom()), fr);
        end
        for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 3'd0, 16'h0, 3'b000, 3'b111);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule